// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

The block links two buses, A and B, through a set of independent lanes called halves. Each half carries one byte in each direction. Each direction has its own storage register and three active-low controls: a path enable, a capture control and an output control. With these a value can flow straight across, be frozen and kept, or be placed on the far bus. Each bus side is modelled as three vectors: incoming data, outgoing data and a per-bit drive enable. No inout nets are used, so the block can sit inside a larger chip and feed its pads.

Storage is synchronous. While a direction's path enable and capture control are both low, its register loads the incoming data on every clock edge. The outgoing data bypasses the register, so the far side follows the input within the same cycle. When either control goes high the path closes. The register then keeps the value taken at the last edge on which the path was open. An asynchronous reset stands in for power-up. If both directions of one half drive at the same time, a per-half flag reports the conflict.

Top module: `latch_xcvr`

## Requirements
- R1: While `rst_n` is low, every bit of `a_oe` and `b_oe` is 0 and every storage register is cleared to zero. After release, a path that is driven without being opened first shows 0x00.
- R2: When a direction's path enable and capture control are both low, its output data equals its input data in the same cycle, and the register loads that data at each rising clock edge.
- R3: When the capture control goes high while the path enable is low, the output shows the value loaded at the last edge on which the path was open. Later input changes do not reach it.
- R4: When the path enable goes high while the capture control is low, the path closes in the same way as in R3. The value shown once the path drives again is the one loaded at the last open edge.
- R5: A direction's drive-enable bits are all 1 only when its path enable and output control are both low. Otherwise they are all 0 and its output data reads 0x00.
- R6: With the output control high, nothing is driven, but loading into the register still follows R2. Lowering the output control later shows the loaded value.
- R7: While the capture control is high, the stored value does not change, whatever the input and path enable do.
- R8: The B-to-A direction follows R2 to R7 with its own three controls, taking `b_in` and driving `a_out`/`a_oe`.
- R9: Halves are independent. Half h uses control bit h and data bits [h*8+7 : h*8]. The controls of one half leave the outputs of the other half unchanged.
- R10: `conflict[h]` is 1 exactly when both directions of half h drive at the same time. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the storage registers |
| rst_n | input | 1 | Asynchronous active-low reset, used as power-up |
| ab_en_n | input | HALVES | A-to-B path enable per half, active low |
| ab_le_n | input | HALVES | A-to-B capture control per half, active low |
| ab_oe_n | input | HALVES | A-to-B output control per half, active low |
| ba_en_n | input | HALVES | B-to-A path enable per half, active low |
| ba_le_n | input | HALVES | B-to-A capture control per half, active low |
| ba_oe_n | input | HALVES | B-to-A output control per half, active low |
| a_in | input | HALVES*LANE_W | Data arriving from bus A |
| a_out | output | HALVES*LANE_W | Data presented to bus A |
| a_oe | output | HALVES*LANE_W | Per-bit drive enable toward bus A |
| b_in | input | HALVES*LANE_W | Data arriving from bus B |
| b_out | output | HALVES*LANE_W | Data presented to bus B |
| b_oe | output | HALVES*LANE_W | Per-bit drive enable toward bus B |
| conflict | output | HALVES | Both directions of a half are driving |

## Verification
The hardest case to reach is a capture through the path enable rather than the capture control. The register's content only becomes visible after the path enable is lowered again while the capture control is high. Otherwise a fresh transparent load hides the stored value. The stimulus therefore opens the path with one byte, raises the path enable while it changes the input, and then drives with the capture control high, expecting the first byte. A second hard case is loading while the outputs are off. The bench loads under a high output control and only then reveals the value.

// File: rtl/lx_pkg.sv
package lx_pkg;

   // one direction's three active-low controls
   typedef struct packed {
      logic en_n;
      logic le_n;
      logic oe_n;
   } lx_ctl_t;

   function automatic logic lx_open(input lx_ctl_t c);
      return !c.en_n && !c.le_n;
   endfunction

   function automatic logic lx_show(input lx_ctl_t c);
      return !c.en_n && !c.oe_n;
   endfunction

endpackage

// File: rtl/lx_path.sv
module lx_path
   import lx_pkg::*;
#(
   parameter int W         = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  lx_ctl_t      ctl,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         drive
);

   logic [W-1:0] store;
   logic [W-1:0] view;
   logic         open;
   logic         show;

   assign open = lx_open(ctl);
   assign show = lx_show(ctl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         store <= '0;
      else if (open)
         store <= din;
   end

   assign view  = open ? din : store;
   assign drive = rst_n && show;

   generate
      if (PARK_ZERO) begin : g_park
         assign dout = drive ? view : '0;

         // R5
         park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !drive |-> (dout == '0));
      end else begin : g_raw
         assign dout = view;
      end
   endgenerate

   // R7
   hold_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(store));

   // R2
   load_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open |=> (store == $past(din)));

   // R3
   shown_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && !open) |-> (dout == store));

   // R1
   always_comb begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!drive);
      end
   end

endmodule

// File: rtl/lx_half.sv
module lx_half
   import lx_pkg::*;
#(
   parameter int W         = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  lx_ctl_t      ab_ctl,
   input  lx_ctl_t      ba_ctl,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe,
   output logic         conflict
);

   logic drv_ab;
   logic drv_ba;

   lx_path #(.W(W), .PARK_ZERO(PARK_ZERO)) u_ab (
      .clk  (clk),
      .rst_n(rst_n),
      .ctl  (ab_ctl),
      .din  (a_in),
      .dout (b_out),
      .drive(drv_ab)
   );

   lx_path #(.W(W), .PARK_ZERO(PARK_ZERO)) u_ba (
      .clk  (clk),
      .rst_n(rst_n),
      .ctl  (ba_ctl),
      .din  (b_in),
      .dout (a_out),
      .drive(drv_ba)
   );

   assign b_oe     = {W{drv_ab}};
   assign a_oe     = {W{drv_ba}};
   assign conflict = drv_ab && drv_ba;

   // R10
   conflict_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conflict |-> (a_oe[0] && b_oe[0]));

   // R10
   conflict_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe[W-1] && b_oe[W-1]) |-> conflict);

endmodule

// File: rtl/latch_xcvr.sv
module latch_xcvr
   import lx_pkg::*;
#(
   parameter int HALVES    = 2,
   parameter int LANE_W    = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [HALVES-1:0]          ab_en_n,
   input  logic [HALVES-1:0]          ab_le_n,
   input  logic [HALVES-1:0]          ab_oe_n,
   input  logic [HALVES-1:0]          ba_en_n,
   input  logic [HALVES-1:0]          ba_le_n,
   input  logic [HALVES-1:0]          ba_oe_n,
   input  logic [HALVES*LANE_W-1:0]   a_in,
   output logic [HALVES*LANE_W-1:0]   a_out,
   output logic [HALVES*LANE_W-1:0]   a_oe,
   input  logic [HALVES*LANE_W-1:0]   b_in,
   output logic [HALVES*LANE_W-1:0]   b_out,
   output logic [HALVES*LANE_W-1:0]   b_oe,
   output logic [HALVES-1:0]          conflict
);

   localparam int BUS_W = HALVES * LANE_W;

   generate
      if (HALVES < 1) begin : g_bad_halves
         $error("latch_xcvr: HALVES must be at least 1");
      end
      if (LANE_W < 1) begin : g_bad_lane
         $error("latch_xcvr: LANE_W must be at least 1");
      end
      if (BUS_W > 4096) begin : g_bad_bus
         $error("latch_xcvr: bus wider than supported");
      end
   endgenerate

   genvar h;
   generate
      for (h = 0; h < HALVES; h++) begin : g_half
         lx_ctl_t ab_ctl;
         lx_ctl_t ba_ctl;

         assign ab_ctl = '{en_n: ab_en_n[h], le_n: ab_le_n[h], oe_n: ab_oe_n[h]};
         assign ba_ctl = '{en_n: ba_en_n[h], le_n: ba_le_n[h], oe_n: ba_oe_n[h]};

         lx_half #(.W(LANE_W), .PARK_ZERO(PARK_ZERO)) u_half (
            .clk     (clk),
            .rst_n   (rst_n),
            .ab_ctl  (ab_ctl),
            .ba_ctl  (ba_ctl),
            .a_in    (a_in [h*LANE_W +: LANE_W]),
            .b_in    (b_in [h*LANE_W +: LANE_W]),
            .a_out   (a_out[h*LANE_W +: LANE_W]),
            .a_oe    (a_oe [h*LANE_W +: LANE_W]),
            .b_out   (b_out[h*LANE_W +: LANE_W]),
            .b_oe    (b_oe [h*LANE_W +: LANE_W]),
            .conflict(conflict[h])
         );
      end
   endgenerate

   // R9
   own_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_en_n[0] && ba_en_n[0]) |-> (a_oe[LANE_W-1:0] == '0 && b_oe[LANE_W-1:0] == '0));

endmodule

// File: tb/latch_xcvr_test.sv
module latch_xcvr_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  ab_en_n, ab_le_n, ab_oe_n;
   logic [1:0]  ba_en_n, ba_le_n, ba_oe_n;
   logic [15:0] a_in, b_in;
   logic [15:0] a_out, a_oe, b_out, b_oe;
   logic [1:0]  conflict;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;   // 50 MHz

   latch_xcvr uut (
      .clk(clk), .rst_n(rst_n),
      .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
      .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .conflict(conflict)
   );

   // fields: req[23:20], {en,le,oe}[19:17], a[16:9], drive[8], b[7:0]
   localparam logic [23:0] VEC [12] = '{
      {4'd2, 3'b000, 8'h3C, 1'b1, 8'h3C},  // R2 transparent
      {4'd2, 3'b000, 8'hA5, 1'b1, 8'hA5},  // R2 follows new data
      {4'd3, 3'b010, 8'h5A, 1'b1, 8'hA5},  // R3 capture control closes
      {4'd7, 3'b010, 8'hFF, 1'b1, 8'hA5},  // R7 held
      {4'd5, 3'b011, 8'h11, 1'b0, 8'h00},  // R5 output control high
      {4'd6, 3'b001, 8'h77, 1'b0, 8'h00},  // R6 loads while off
      {4'd6, 3'b010, 8'h00, 1'b1, 8'h77},  // R6 reveal
      {4'd5, 3'b100, 8'h99, 1'b0, 8'h00},  // R5 path enable high
      {4'd7, 3'b010, 8'h99, 1'b1, 8'h77},  // R7 nothing loaded
      {4'd2, 3'b000, 8'hC3, 1'b1, 8'hC3},  // R2 reopen
      {4'd4, 3'b100, 8'h0F, 1'b0, 8'h00},  // R4 path enable closes
      {4'd4, 3'b010, 8'h0F, 1'b1, 8'hC3}   // R4 stored value shown
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      @(posedge clk);
      #5;
   endtask

   initial begin
      rst_n = 1'b0;
      ab_en_n = '1; ab_le_n = '1; ab_oe_n = '1;
      ba_en_n = '1; ba_le_n = '1; ba_oe_n = '1;
      a_in = '0; b_in = '0;
      repeat (3) @(posedge clk);
      #5;
      chk("R1 a_oe in reset", a_oe, 0);
      chk("R1 b_oe in reset", b_oe, 0);
      chk("R10 no conflict in reset", conflict, 0);

      @(negedge clk);
      rst_n = 1'b1;
      ab_en_n[0] = 1'b0; ab_oe_n[0] = 1'b0;
      settle();
      chk("R1 cleared storage", b_out[7:0], 8'h00);
      chk("R5 drive with en and oe low", b_oe[7:0], 8'hFF);

      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         {ab_en_n[0], ab_le_n[0], ab_oe_n[0]} = VEC[i][19:17];
         a_in[7:0] = VEC[i][16:9];
         settle();
         chk($sformatf("R%0d vec%0d b_out", VEC[i][23:20], i), b_out[7:0], VEC[i][7:0]);
         chk($sformatf("R%0d vec%0d b_oe", VEC[i][23:20], i), b_oe[7:0], {8{VEC[i][8]}});
         chk($sformatf("R10 vec%0d quiet", i), conflict, 0);
      end

      // R8 B-to-A with its own controls
      @(negedge clk);
      ab_en_n[0] = 1'b1; ab_le_n[0] = 1'b1; ab_oe_n[0] = 1'b1;
      ba_en_n[0] = 1'b0; ba_le_n[0] = 1'b0; ba_oe_n[0] = 1'b0;
      b_in[7:0] = 8'h6E;
      settle();
      chk("R8 transparent a_out", a_out[7:0], 8'h6E);
      chk("R8 a_oe driven", a_oe[7:0], 8'hFF);
      chk("R8 b side off", b_oe[7:0], 8'h00);
      @(negedge clk);
      ba_le_n[0] = 1'b1;
      b_in[7:0] = 8'h00;
      settle();
      chk("R8 captured a_out", a_out[7:0], 8'h6E);

      // R10 both directions drive
      @(negedge clk);
      ab_en_n[0] = 1'b0; ab_oe_n[0] = 1'b0;
      settle();
      chk("R10 conflict raised", conflict, 2'b01);
      @(negedge clk);
      ab_oe_n[0] = 1'b1;
      settle();
      chk("R10 conflict cleared", conflict, 2'b00);

      // R9 other half independent
      @(negedge clk);
      ab_en_n[0] = 1'b1; ab_le_n[0] = 1'b1; ab_oe_n[0] = 1'b1;
      ba_en_n[0] = 1'b1; ba_le_n[0] = 1'b1; ba_oe_n[0] = 1'b1;
      ab_en_n[1] = 1'b0; ab_le_n[1] = 1'b0; ab_oe_n[1] = 1'b0;
      a_in = 16'hE133;
      settle();
      chk("R9 half1 b_out", b_out[15:8], 8'hE1);
      chk("R9 half1 b_oe", b_oe[15:8], 8'hFF);
      chk("R9 half0 b_oe untouched", b_oe[7:0], 8'h00);
      chk("R9 half0 a_oe untouched", a_oe[7:0], 8'h00);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #5;
      chk("R1 b_oe off in reset", b_oe, 0);
      chk("R1 a_oe off in reset", a_oe, 0);
      @(negedge clk);
      rst_n = 1'b1;
      ab_le_n[1] = 1'b1;
      settle();
      chk("R1 half1 storage cleared", b_out[15:8], 8'h00);
      chk("R1 half1 driving again", b_oe[15:8], 8'hFF);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule